// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block prepares two active-low external interrupt pins for a small CPU core. The first pin is a maskable request. Software sets an enable bit and a trigger-mode bit, and the pin is then sensed either while it is low or when it falls. The second pin is a non-maskable request. It stays inert until software clears the core's X mask, and X can never be set again before the next reset.

Both pins pass through a two-flop synchronizer and then act with no glitch filtering. One sampled active level or one sampled falling edge is enough. In edge mode a falling edge is held in a latch until the CPU acknowledges it or software clears it with a write strobe. A wake-up output is raised while the core is in stop mode and either request is active. When the enable bit is dropped, a pending maskable request is withdrawn at once and any latched edge is discarded.

Top module: `xreq_cond`

## Requirements
- R1: After reset the enable bit is 0, the trigger mode is level (mode bit 0), X reads 1, and mreq_req, nmreq_req and wake_req are all 0.
- R2: mreq_req is 1 only while the enable bit is 1 and cpu_imask is 0. A captured request that is held off by cpu_imask appears once cpu_imask clears.
- R3: In level mode (mode bit 0), mreq_req follows the inverted pin with a delay of two clock edges. A low level sampled by the synchronizer asserts the request, and a high level removes it.
- R4: In edge mode (mode bit 1), a sampled falling edge sets a latch. The request stays asserted after the pin returns high, until mreq_ack or edge_clr is pulsed for one cycle.
- R5: Writing the enable bit to 0 deasserts mreq_req in the cycle after the write and discards a latched edge. Re-enabling without a new edge gives no request.
- R6: While X is 1, the non-maskable pin has no effect on nmreq_req. Once X is 0, a low level on that pin asserts nmreq_req two edges later, and a high level removes it.
- R7: A write with xmask_wdata 0 clears X. A later write with xmask_wdata 1 leaves X at 0 until reset.
- R8: wake_req equals stop_mode AND (mreq_req OR nmreq_req).
- R9: There is no pulse filter. A low pulse lasting a single clock cycle on the maskable pin in edge mode is latched as a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mpin_n | input | 1 | Maskable request pin, active low, asynchronous |
| npin_n | input | 1 | Non-maskable request pin, active low, asynchronous |
| ctl_wr | input | 1 | Write strobe for the enable and mode bits |
| ctl_en_wdata | input | 1 | Enable value written by ctl_wr |
| ctl_mode_wdata | input | 1 | Trigger mode written by ctl_wr: 0 low level, 1 falling edge |
| cpu_imask | input | 1 | CPU I mask; 1 holds off the maskable request |
| xmask_wr | input | 1 | Write strobe for the X mask |
| xmask_wdata | input | 1 | X value written; only 0 takes effect |
| edge_clr | input | 1 | Write strobe that clears the edge latch |
| mreq_ack | input | 1 | CPU acknowledge of the maskable request |
| stop_mode | input | 1 | Core is in stop mode |
| mreq_req | output | 1 | Maskable request to the CPU |
| nmreq_req | output | 1 | Non-maskable request to the CPU |
| wake_req | output | 1 | Wake-up request out of stop mode |
| xmask_q | output | 1 | Current X mask state |

## Verification
The hardest case to reach is a latched edge that must be thrown away when the enable bit drops, because the request output looks the same whether the latch was cleared or only masked. To expose the latch, the bench latches an edge, drops the enable bit, restores it with the pin held high, and checks that no request comes back. The single-cycle pin pulse is timed at the falling clock edge so that the synchronizer captures exactly one low sample. The bench also tries to set X again after clearing it, and then checks that the non-maskable pin still reaches the output.

// File: rtl/xreq_cond_pkg.sv
package xreq_cond_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xreq_mask_path.sv
module xreq_mask_path
  import xreq_cond_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_s_n,
  input  logic  en,
  input  trig_e mode,
  input  logic  imask,
  input  logic  clr,
  output logic  req
);
  logic prev_q;
  logic latch_q;
  logic fall;

  assign fall = prev_q & ~pin_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_s_n;
      if (!en || mode != TRIG_FALL)    latch_q <= 1'b0;
      else if (fall)                   latch_q <= 1'b1;
      else if (clr)                    latch_q <= 1'b0;
    end
  end

  always_comb begin
    req = 1'b0;
    if (en && !imask) begin
      if (mode == TRIG_FALL) req = latch_q;
      else                   req = ~pin_s_n;
    end
  end
endmodule

// File: rtl/xreq_nmi_gate.sv
module xreq_nmi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_n,
  input  logic wr,
  input  logic wdata,
  output logic xmask,
  output logic req
);
  logic x_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             x_q <= 1'b1;
    else if (wr && !wdata)  x_q <= 1'b0;
  end

  assign xmask = x_q;
  assign req   = ~x_q & ~pin_s_n;
endmodule

// File: rtl/xreq_cond.sv
module xreq_cond
  import xreq_cond_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mpin_n,
  input  logic npin_n,
  input  logic ctl_wr,
  input  logic ctl_en_wdata,
  input  logic ctl_mode_wdata,
  input  logic cpu_imask,
  input  logic xmask_wr,
  input  logic xmask_wdata,
  input  logic edge_clr,
  input  logic mreq_ack,
  input  logic stop_mode,
  output logic mreq_req,
  output logic nmreq_req,
  output logic wake_req,
  output logic xmask_q
);
  logic [1:0] pins_s;
  logic       en_q;
  trig_e      mode_q;

  xreq_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH), .RST_VAL(2'b11)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({npin_n, mpin_n}),
    .sync_o  (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= TRIG_LEVEL;
    end else if (ctl_wr) begin
      en_q   <= ctl_en_wdata;
      mode_q <= trig_e'(ctl_mode_wdata);
    end
  end

  xreq_mask_path u_mpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_s_n (pins_s[0]),
    .en      (en_q),
    .mode    (mode_q),
    .imask   (cpu_imask),
    .clr     (edge_clr | mreq_ack),
    .req     (mreq_req)
  );

  xreq_nmi_gate u_ngate (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_s_n (pins_s[1]),
    .wr      (xmask_wr),
    .wdata   (xmask_wdata),
    .xmask   (xmask_q),
    .req     (nmreq_req)
  );

  assign wake_req = stop_mode & (mreq_req | nmreq_req);
endmodule

// File: rtl/xreq_cond_chk.sv
module xreq_cond_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic cpu_imask,
  input logic stop_mode,
  input logic mreq_req,
  input logic nmreq_req,
  input logic wake_req,
  input logic xmask_q
);
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_req |-> (en_q && !cpu_imask));

  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !mreq_req);

  a_r6_nmi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    xmask_q |-> !nmreq_req);

  a_r7_x_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !xmask_q |=> !xmask_q);

  a_r8_wake_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> stop_mode);
endmodule

bind xreq_cond xreq_cond_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .cpu_imask (cpu_imask),
  .stop_mode (stop_mode),
  .mreq_req  (mreq_req),
  .nmreq_req (nmreq_req),
  .wake_req  (wake_req),
  .xmask_q   (xmask_q)
);

// File: tb/sim_xreq_cond.sv
module sim_xreq_cond;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mpin_n = 1'b1, npin_n = 1'b1;
  logic ctl_wr = 1'b0, ctl_en_wdata = 1'b0, ctl_mode_wdata = 1'b0;
  logic cpu_imask = 1'b0, xmask_wr = 1'b0, xmask_wdata = 1'b0;
  logic edge_clr = 1'b0, mreq_ack = 1'b0, stop_mode = 1'b0;
  logic mreq_req, nmreq_req, wake_req, xmask_q;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  xreq_cond u0 (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic mode);
    ctl_wr = 1'b1; ctl_en_wdata = en; ctl_mode_wdata = mode;
    step(1);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_x(input logic v);
    xmask_wr = 1'b1; xmask_wdata = v;
    step(1);
    xmask_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mreq", mreq_req, 1'b0);
    chk("R1 nmreq", nmreq_req, 1'b0);
    chk("R1 wake", wake_req, 1'b0);
    chk("R1 xmask", xmask_q, 1'b1);
    mpin_n = 1'b0;
    step(3);
    chk("R1 disabled out of reset", mreq_req, 1'b0);
    mpin_n = 1'b1;
    step(3);
  endtask

  task automatic t_level;
    wr_ctl(1'b1, 1'b0);
    mpin_n = 1'b0;
    step(1);
    chk("R3 not yet after one edge", mreq_req, 1'b0);
    step(1);
    chk("R3 asserted after two edges", mreq_req, 1'b1);
    cpu_imask = 1'b1;
    #1 chk("R2 masked by I", mreq_req, 1'b0);
    cpu_imask = 1'b0;
    #1 chk("R2 released when I clears", mreq_req, 1'b1);
    mpin_n = 1'b1;
    step(2);
    chk("R3 released on high", mreq_req, 1'b0);
  endtask

  task automatic t_edge;
    wr_ctl(1'b1, 1'b1);
    mpin_n = 1'b0;
    step(3);
    chk("R4 edge latched", mreq_req, 1'b1);
    mpin_n = 1'b1;
    step(4);
    chk("R4 held after pin high", mreq_req, 1'b1);
    mreq_ack = 1'b1; step(1); mreq_ack = 1'b0;
    chk("R4 cleared by ack", mreq_req, 1'b0);
    mpin_n = 1'b0; step(3); mpin_n = 1'b1;
    chk("R4 second edge latched", mreq_req, 1'b1);
    step(2);
    edge_clr = 1'b1; step(1); edge_clr = 1'b0;
    chk("R4 cleared by edge_clr", mreq_req, 1'b0);
  endtask

  task automatic t_cancel;
    mpin_n = 1'b0; step(3); mpin_n = 1'b1;
    step(2);
    chk("R5 pending before cancel", mreq_req, 1'b1);
    wr_ctl(1'b0, 1'b1);
    chk("R5 cancelled at once", mreq_req, 1'b0);
    wr_ctl(1'b1, 1'b1);
    step(2);
    chk("R5 latch discarded", mreq_req, 1'b0);
  endtask

  task automatic t_pulse;
    mpin_n = 1'b0; step(1); mpin_n = 1'b1;
    step(2);
    chk("R9 one-cycle pulse latched", mreq_req, 1'b1);
    mreq_ack = 1'b1; step(1); mreq_ack = 1'b0;
  endtask

  task automatic t_nmi;
    npin_n = 1'b0;
    step(3);
    chk("R6 ignored while X set", nmreq_req, 1'b0);
    wr_x(1'b0);
    chk("R7 X cleared", xmask_q, 1'b0);
    chk("R6 active once X clear", nmreq_req, 1'b1);
    wr_x(1'b1);
    chk("R7 X cannot be set again", xmask_q, 1'b0);
    chk("R7 nmi still active", nmreq_req, 1'b1);
    npin_n = 1'b1;
    step(2);
    chk("R6 released on high", nmreq_req, 1'b0);
  endtask

  task automatic t_wake;
    npin_n = 1'b0; step(2);
    chk("R8 no wake outside stop", wake_req, 1'b0);
    stop_mode = 1'b1;
    #1 chk("R8 wake from nmi", wake_req, 1'b1);
    npin_n = 1'b1; step(2);
    chk("R8 no wake with no request", wake_req, 1'b0);
    mpin_n = 1'b0; step(3); mpin_n = 1'b1;
    chk("R8 wake from maskable", wake_req, 1'b1);
    stop_mode = 1'b0;
    #1 chk("R8 wake drops with stop", wake_req, 1'b0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_level();
    t_edge();
    t_cancel();
    t_pulse();
    t_nmi();
    t_wake();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule